// File: doc/BRIEF.md
# Bulk Transfer Descriptor Retirement Unit

This block keeps the live state of one bulk transfer descriptor inside a USB host controller: an active flag, a halted flag, a small error-retry counter, the count of bytes still to be moved and the token type (OUT, IN or SETUP). Software, or the schedule walker that fetches descriptors, writes these fields through a load port. After that, the block updates them from the result of each bus transaction. The result arrives as three strobes: a successful data transaction with its byte count, a transaction error, or a STALL handshake.

On each result the block decides whether the descriptor carries on or finishes. There are two kinds of finish. A STALL, or an error that uses up the retry counter, halts the pipe: the queue is frozen until software reloads the descriptor. Running out of bytes, or a short IN packet, simply retires the descriptor. The block then sends a one-cycle advance pulse to the queue-advance stage. For a short packet it also raises a separate short flag, so that the advance stage can act on that condition itself.

Every update is registered and shows at the outputs one clock after the strobe. A three-bit reason code holds the cause of the last finish until the next load.

Top module: `bulk_xfer_retire`

## Requirements
- R1: After reset, desc_active, desc_halted, advance_queue and short_pkt are 0. desc_err_cnt and desc_bytes_left are 0, and finish_reason is 0 (code 0 = no finish).
- R2: A STALL strobe on an active descriptor halts it, one clock later. desc_halted becomes 1, desc_active becomes 0 and finish_reason becomes 2. The error counter and the byte count are left unchanged, and no advance pulse is sent.
- R3: An error strobe on an active descriptor lowers a nonzero error counter by one. If the counter reaches 0 this way, the descriptor halts with finish_reason 1 and no advance pulse. If the counter is already 0, an error leaves it at 0 and the descriptor stays active.
- R4: A successful transaction subtracts the bytes moved from desc_bytes_left, clamping at 0, and leaves the error counter unchanged.
- R5: If desc_bytes_left is 0 after a successful transaction, the descriptor retires without halting and finish_reason becomes 3. This includes a zero-length transaction on a count that was already 0.
- R6: A successful transaction with token code 2'b01 (IN) that moves fewer bytes than the maximum packet length, and leaves a nonzero count, retires the descriptor. finish_reason becomes 4 and short_pkt is raised. For OUT (2'b00) or SETUP (2'b10), a short transfer does not end the descriptor.
- R7: When conditions fall in the same cycle, the first one in this list wins: STALL, then error-counter exhaustion, then byte exhaustion, then short packet. When the error strobe comes with the success strobe, the error wins and no bytes are counted.
- R8: While desc_active is 0, all three result strobes are ignored: every descriptor field and finish_reason keep their values. A halt persists until the next load.
- R9: advance_queue is a one-cycle pulse. It is sent in exactly the cycle in which a strobe has just cleared desc_active without setting desc_halted. short_pkt is only ever high together with advance_queue.
- R10: A load writes all five fields and clears finish_reason to 0 one clock later. A load takes priority over any result strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write descriptor fields from the ld_* inputs |
| ld_active | input | 1 | Active flag to load |
| ld_halted | input | 1 | Halted flag to load |
| ld_err_cnt | input | CERR_W (2) | Error retry counter to load |
| ld_bytes | input | BYTE_W (15) | Bytes remaining to load |
| ld_token | input | 2 | Token code to load: 00 OUT, 01 IN, 10 SETUP |
| txn_ok | input | 1 | Strobe: data transaction completed successfully |
| txn_err | input | 1 | Strobe: transaction error |
| txn_stall | input | 1 | Strobe: device answered with STALL |
| txn_moved | input | PKT_W (11) | Bytes moved by this transaction |
| max_pkt | input | PKT_W (11) | Maximum packet length of the endpoint |
| desc_active | output | 1 | Current active flag |
| desc_halted | output | 1 | Current halted flag |
| desc_err_cnt | output | CERR_W (2) | Current error counter |
| desc_bytes_left | output | BYTE_W (15) | Current bytes remaining |
| desc_token | output | 2 | Current token code |
| finish_reason | output | 3 | 0 none, 1 error halt, 2 stall halt, 3 bytes done, 4 short IN |
| advance_queue | output | 1 | One-cycle pulse: queue may advance |
| short_pkt | output | 1 | Short-packet flag, valid with advance_queue |

## Verification
The main collision is a STALL, or a final error, in the same cycle as another result. Byte exhaustion and a short IN packet can also fall in one cycle. The bench drives the STALL and error strobes together with the counter at 1, drives the error and success strobes together, and sends an IN packet that is short and also empties the count. In each case it checks that only the higher-ranked cause is visible one clock later, in the reason code, the halted flag, the advance pulse and the untouched count or counter.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

   typedef enum logic [2:0] {
      RSN_NONE       = 3'd0,
      RSN_ERR_HALT   = 3'd1,
      RSN_STALL_HALT = 3'd2,
      RSN_BYTES_DONE = 3'd3,
      RSN_SHORT_IN   = 3'd4
   } rsn_e;

   localparam logic [1:0] TOKEN_OUT   = 2'b00;
   localparam logic [1:0] TOKEN_IN    = 2'b01;
   localparam logic [1:0] TOKEN_SETUP = 2'b10;

   typedef struct packed {
      logic       active;
      logic       halted;
      logic [2:0] reason;
      logic       advance;
      logic       short_flag;
      logic       use_bytes;
      logic       use_cerr;
   } verdict_t;

endpackage

// File: rtl/bxr_byte_sub.sv
module bxr_byte_sub #(
   parameter int BYTE_W = 15,
   parameter int PKT_W  = 11
) (
   input  logic [BYTE_W-1:0] remain,
   input  logic [PKT_W-1:0]  moved,
   output logic [BYTE_W-1:0] remain_next,
   output logic              exhausted
);

   localparam int WIDE_W = (BYTE_W > PKT_W) ? BYTE_W : PKT_W;
   localparam int SUB_W  = WIDE_W + 1;

   logic [SUB_W-1:0] remain_x;
   logic [SUB_W-1:0] moved_x;
   logic [SUB_W-1:0] diff;

   generate
      if (BYTE_W >= PKT_W) begin : g_count_wider
         assign remain_x = {1'b0, remain};
         assign moved_x  = {{(SUB_W-PKT_W){1'b0}}, moved};
      end else begin : g_packet_wider
         assign remain_x = {{(SUB_W-BYTE_W){1'b0}}, remain};
         assign moved_x  = {1'b0, moved};
      end
   endgenerate

   assign diff = remain_x - moved_x;

   always_comb begin
      if (diff[SUB_W-1]) begin
         remain_next = '0;
      end else begin
         remain_next = diff[BYTE_W-1:0];
      end
   end

   assign exhausted = (remain_next == '0);

endmodule

// File: rtl/bxr_err_count.sv
module bxr_err_count #(
   parameter int CERR_W = 2
) (
   input  logic [CERR_W-1:0] cnt_in,
   input  logic              err_hit,
   output logic [CERR_W-1:0] cnt_next,
   output logic              used_up
);

   localparam logic [CERR_W-1:0] ONE = CERR_W'(1);

   logic nonzero;

   assign nonzero = (cnt_in != '0);

   always_comb begin
      cnt_next = cnt_in;
      used_up  = 1'b0;
      if (err_hit && nonzero) begin
         cnt_next = cnt_in - ONE;
         used_up  = (cnt_in == ONE);
      end
   end

endmodule

// File: rtl/bxr_short_detect.sv
module bxr_short_detect #(
   parameter int PKT_W = 11
) (
   input  logic [1:0]       token,
   input  logic [PKT_W-1:0] moved,
   input  logic [PKT_W-1:0] max_pkt,
   output logic             is_short
);
   import bxr_pkg::*;

   logic token_in;
   logic below_max;

   assign token_in  = (token == TOKEN_IN);
   assign below_max = (moved < max_pkt);
   assign is_short  = token_in && below_max;

endmodule

// File: rtl/bxr_retire_decide.sv
module bxr_retire_decide (
   input  logic                    active,
   input  logic                    halted,
   input  logic                    ok,
   input  logic                    err,
   input  logic                    stall,
   input  logic                    err_used_up,
   input  logic                    bytes_gone,
   input  logic                    short_in,
   output bxr_pkg::verdict_t       verdict
);
   import bxr_pkg::*;

   always_comb begin
      verdict            = '0;
      verdict.active     = active;
      verdict.halted     = halted;
      verdict.reason     = RSN_NONE;
      if (stall) begin
         verdict.active = 1'b0;
         verdict.halted = 1'b1;
         verdict.reason = RSN_STALL_HALT;
      end else if (err) begin
         verdict.use_cerr = 1'b1;
         if (err_used_up) begin
            verdict.active = 1'b0;
            verdict.halted = 1'b1;
            verdict.reason = RSN_ERR_HALT;
         end
      end else if (ok) begin
         verdict.use_bytes = 1'b1;
         if (bytes_gone) begin
            verdict.active  = 1'b0;
            verdict.reason  = RSN_BYTES_DONE;
            verdict.advance = 1'b1;
         end else if (short_in) begin
            verdict.active     = 1'b0;
            verdict.reason     = RSN_SHORT_IN;
            verdict.advance    = 1'b1;
            verdict.short_flag = 1'b1;
         end
      end
   end

endmodule

// File: rtl/bulk_xfer_retire.sv
module bulk_xfer_retire #(
   parameter int BYTE_W = 15,
   parameter int PKT_W  = 11,
   parameter int CERR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              ld_active,
   input  logic              ld_halted,
   input  logic [CERR_W-1:0] ld_err_cnt,
   input  logic [BYTE_W-1:0] ld_bytes,
   input  logic [1:0]        ld_token,
   input  logic              txn_ok,
   input  logic              txn_err,
   input  logic              txn_stall,
   input  logic [PKT_W-1:0]  txn_moved,
   input  logic [PKT_W-1:0]  max_pkt,
   output logic              desc_active,
   output logic              desc_halted,
   output logic [CERR_W-1:0] desc_err_cnt,
   output logic [BYTE_W-1:0] desc_bytes_left,
   output logic [1:0]        desc_token,
   output logic [2:0]        finish_reason,
   output logic              advance_queue,
   output logic              short_pkt
);
   import bxr_pkg::*;

   initial begin
      assert (BYTE_W >= 2 && BYTE_W <= 32)
         else $error("bulk_xfer_retire: BYTE_W out of range");
      assert (PKT_W >= 1 && PKT_W <= 16)
         else $error("bulk_xfer_retire: PKT_W out of range");
      assert (CERR_W >= 1 && CERR_W <= 8)
         else $error("bulk_xfer_retire: CERR_W out of range");
   end

   logic [BYTE_W-1:0] bytes_next;
   logic              bytes_gone;
   logic [CERR_W-1:0] cerr_next;
   logic              cerr_used_up;
   logic              short_in;
   logic              any_strobe;
   logic              take_result;
   verdict_t          verdict;

   bxr_byte_sub #(
      .BYTE_W (BYTE_W),
      .PKT_W  (PKT_W)
   ) u_sub (
      .remain      (desc_bytes_left),
      .moved       (txn_moved),
      .remain_next (bytes_next),
      .exhausted   (bytes_gone)
   );

   bxr_err_count #(
      .CERR_W (CERR_W)
   ) u_cerr (
      .cnt_in   (desc_err_cnt),
      .err_hit  (txn_err),
      .cnt_next (cerr_next),
      .used_up  (cerr_used_up)
   );

   bxr_short_detect #(
      .PKT_W (PKT_W)
   ) u_short (
      .token    (desc_token),
      .moved    (txn_moved),
      .max_pkt  (max_pkt),
      .is_short (short_in)
   );

   bxr_retire_decide u_decide (
      .active      (desc_active),
      .halted      (desc_halted),
      .ok          (txn_ok),
      .err         (txn_err),
      .stall       (txn_stall),
      .err_used_up (cerr_used_up),
      .bytes_gone  (bytes_gone),
      .short_in    (short_in),
      .verdict     (verdict)
   );

   assign any_strobe  = txn_ok | txn_err | txn_stall;
   assign take_result = !load_en && desc_active && any_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_active     <= 1'b0;
         desc_halted     <= 1'b0;
         desc_err_cnt    <= '0;
         desc_bytes_left <= '0;
         desc_token      <= TOKEN_OUT;
         finish_reason   <= RSN_NONE;
      end else if (load_en) begin
         desc_active     <= ld_active;
         desc_halted     <= ld_halted;
         desc_err_cnt    <= ld_err_cnt;
         desc_bytes_left <= ld_bytes;
         desc_token      <= ld_token;
         finish_reason   <= RSN_NONE;
      end else if (take_result) begin
         desc_active   <= verdict.active;
         desc_halted   <= verdict.halted;
         finish_reason <= verdict.reason;
         if (verdict.use_cerr) begin
            desc_err_cnt <= cerr_next;
         end
         if (verdict.use_bytes) begin
            desc_bytes_left <= bytes_next;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         advance_queue <= 1'b0;
         short_pkt     <= 1'b0;
      end else begin
         advance_queue <= take_result && verdict.advance;
         short_pkt     <= take_result && verdict.short_flag;
      end
   end

endmodule

// File: rtl/bxr_retire_chk.sv
module bxr_retire_chk #(
   parameter int BYTE_W = 15,
   parameter int PKT_W  = 11,
   parameter int CERR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic              txn_ok,
   input logic              txn_err,
   input logic              txn_stall,
   input logic              desc_active,
   input logic              desc_halted,
   input logic [CERR_W-1:0] desc_err_cnt,
   input logic [BYTE_W-1:0] desc_bytes_left,
   input logic [2:0]        finish_reason,
   input logic              advance_queue,
   input logic              short_pkt
);
   import bxr_pkg::*;

   localparam logic [CERR_W-1:0] ONE = CERR_W'(1);

   // R2
   p_stall_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_active && txn_stall && !load_en) |=>
      (desc_halted && !desc_active && finish_reason == RSN_STALL_HALT && !advance_queue));

   // R3
   p_err_exhaust_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_active && txn_err && !txn_stall && !load_en && desc_err_cnt == ONE) |=>
      (desc_halted && !desc_active && finish_reason == RSN_ERR_HALT));

   // R3
   p_err_zero_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_active && txn_err && !txn_stall && !load_en && desc_err_cnt == '0) |=>
      (desc_active && desc_err_cnt == '0));

   // R8
   p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_active && !load_en) |=>
      ($stable(desc_bytes_left) && $stable(desc_err_cnt) && $stable(desc_halted)
       && $stable(finish_reason) && !advance_queue));

   // R9
   p_adv_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      advance_queue |=> !advance_queue);

   // R9
   p_short_with_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      short_pkt |-> advance_queue);

   // R9
   p_no_adv_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      advance_queue |-> (!desc_halted && !desc_active));

   // R9
   p_adv_on_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(desc_active) && !$past(load_en) && !desc_active && !desc_halted) |-> advance_queue);

endmodule

bind bulk_xfer_retire bxr_retire_chk #(
   .BYTE_W (BYTE_W),
   .PKT_W  (PKT_W),
   .CERR_W (CERR_W)
) u_chk (.*);

// File: tb/bulk_xfer_retire_test.sv
module bulk_xfer_retire_test;

   localparam int BYTE_W = 15;
   localparam int PKT_W  = 11;
   localparam int CERR_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_en = 1'b0;
   logic              ld_active = 1'b0;
   logic              ld_halted = 1'b0;
   logic [CERR_W-1:0] ld_err_cnt = '0;
   logic [BYTE_W-1:0] ld_bytes = '0;
   logic [1:0]        ld_token = 2'b00;
   logic              txn_ok = 1'b0;
   logic              txn_err = 1'b0;
   logic              txn_stall = 1'b0;
   logic [PKT_W-1:0]  txn_moved = '0;
   logic [PKT_W-1:0]  max_pkt = '0;
   logic              desc_active;
   logic              desc_halted;
   logic [CERR_W-1:0] desc_err_cnt;
   logic [BYTE_W-1:0] desc_bytes_left;
   logic [1:0]        desc_token;
   logic [2:0]        finish_reason;
   logic              advance_queue;
   logic              short_pkt;

   int total_checks = 0;
   int bad_checks   = 0;
   bit finished     = 1'b0;

   always #5 clk = ~clk;

   bulk_xfer_retire #(
      .BYTE_W (BYTE_W),
      .PKT_W  (PKT_W),
      .CERR_W (CERR_W)
   ) uut (
      .clk (clk), .rst_n (rst_n), .load_en (load_en),
      .ld_active (ld_active), .ld_halted (ld_halted), .ld_err_cnt (ld_err_cnt),
      .ld_bytes (ld_bytes), .ld_token (ld_token),
      .txn_ok (txn_ok), .txn_err (txn_err), .txn_stall (txn_stall),
      .txn_moved (txn_moved), .max_pkt (max_pkt),
      .desc_active (desc_active), .desc_halted (desc_halted),
      .desc_err_cnt (desc_err_cnt), .desc_bytes_left (desc_bytes_left),
      .desc_token (desc_token), .finish_reason (finish_reason),
      .advance_queue (advance_queue), .short_pkt (short_pkt)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total_checks++;
      if (act != exp) begin
         bad_checks++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic load_desc(input bit act, input bit hlt, input int cerr, input int bytes,
                            input int tok);
      @(negedge clk);
      load_en    = 1'b1;
      ld_active  = act;
      ld_halted  = hlt;
      ld_err_cnt = CERR_W'(cerr);
      ld_bytes   = BYTE_W'(bytes);
      ld_token   = 2'(tok);
      @(posedge clk);
      @(negedge clk);
      load_en = 1'b0;
   endtask

   // strobes applied for one edge; returns at the following falling edge
   task automatic txn(input bit ok, input bit err, input bit stall, input int moved,
                      input int maxp);
      txn_ok    = ok;
      txn_err   = err;
      txn_stall = stall;
      txn_moved = PKT_W'(moved);
      max_pkt   = PKT_W'(maxp);
      @(posedge clk);
      @(negedge clk);
      txn_ok    = 1'b0;
      txn_err   = 1'b0;
      txn_stall = 1'b0;
   endtask

   task automatic t_reset;
      check("R1", "active", desc_active, 0);
      check("R1", "halted", desc_halted, 0);
      check("R1", "err_cnt", desc_err_cnt, 0);
      check("R1", "bytes", desc_bytes_left, 0);
      check("R1", "reason", finish_reason, 0);
      check("R1", "advance", advance_queue, 0);
      check("R1", "short", short_pkt, 0);
   endtask

   task automatic t_out_full;
      load_desc(1, 0, 3, 1024, 0);
      check("R10", "loaded active", desc_active, 1);
      check("R10", "loaded bytes", desc_bytes_left, 1024);
      txn(1, 0, 0, 512, 512);
      check("R4", "bytes after first packet", desc_bytes_left, 512);
      check("R4", "err_cnt kept", desc_err_cnt, 3);
      check("R4", "still active", desc_active, 1);
      check("R9", "no advance mid transfer", advance_queue, 0);
      txn(1, 0, 0, 512, 512);
      check("R5", "active cleared", desc_active, 0);
      check("R5", "not halted", desc_halted, 0);
      check("R5", "reason bytes done", finish_reason, 3);
      check("R9", "advance pulse", advance_queue, 1);
      check("R9", "no short flag", short_pkt, 0);
      @(negedge clk);
      check("R9", "advance one cycle", advance_queue, 0);
   endtask

   task automatic t_zero_length;
      load_desc(1, 0, 3, 0, 0);
      txn(1, 0, 0, 0, 512);
      check("R5", "zero length retires", desc_active, 0);
      check("R5", "zero length reason", finish_reason, 3);
      check("R5", "zero length advance", advance_queue, 1);
   endtask

   task automatic t_short_in;
      load_desc(1, 0, 3, 1000, 1);
      txn(1, 0, 0, 100, 512);
      check("R6", "short IN bytes", desc_bytes_left, 900);
      check("R6", "short IN retired", desc_active, 0);
      check("R6", "short IN reason", finish_reason, 4);
      check("R6", "short flag", short_pkt, 1);
      check("R6", "short advance", advance_queue, 1);
      @(negedge clk);
      check("R9", "short flag one cycle", short_pkt, 0);
   endtask

   task automatic t_short_out;
      load_desc(1, 0, 3, 1000, 0);
      txn(1, 0, 0, 100, 512);
      check("R6", "short OUT stays active", desc_active, 1);
      check("R6", "short OUT bytes", desc_bytes_left, 900);
      check("R6", "short OUT no flag", short_pkt, 0);
      load_desc(1, 0, 3, 1000, 2);
      txn(1, 0, 0, 8, 64);
      check("R6", "short SETUP stays active", desc_active, 1);
   endtask

   task automatic t_short_and_empty;
      load_desc(1, 0, 3, 100, 1);
      txn(1, 0, 0, 100, 512);
      check("R7", "empty beats short reason", finish_reason, 3);
      check("R7", "empty beats short flag", short_pkt, 0);
      check("R7", "empty advance", advance_queue, 1);
   endtask

   task automatic t_saturate;
      load_desc(1, 0, 3, 50, 0);
      txn(1, 0, 0, 100, 512);
      check("R4", "saturated bytes", desc_bytes_left, 0);
      check("R5", "saturated retires", finish_reason, 3);
   endtask

   task automatic t_error_countdown;
      load_desc(1, 0, 3, 2000, 0);
      txn(0, 1, 0, 0, 512);
      check("R3", "err 3->2", desc_err_cnt, 2);
      check("R3", "still active after err", desc_active, 1);
      txn(0, 1, 0, 0, 512);
      check("R3", "err 2->1", desc_err_cnt, 1);
      txn(0, 1, 0, 0, 512);
      check("R3", "err exhausted count", desc_err_cnt, 0);
      check("R3", "err halted", desc_halted, 1);
      check("R3", "err inactive", desc_active, 0);
      check("R3", "err reason", finish_reason, 1);
      check("R3", "err no advance", advance_queue, 0);
      check("R3", "bytes untouched", desc_bytes_left, 2000);
   endtask

   task automatic t_error_zero;
      load_desc(1, 0, 0, 2000, 0);
      txn(0, 1, 0, 0, 512);
      check("R3", "zero counter stays", desc_err_cnt, 0);
      check("R3", "zero counter active", desc_active, 1);
      check("R3", "zero counter not halted", desc_halted, 0);
   endtask

   task automatic t_stall;
      load_desc(1, 0, 2, 700, 1);
      txn(1, 0, 1, 10, 512);
      check("R2", "stall halted", desc_halted, 1);
      check("R2", "stall inactive", desc_active, 0);
      check("R2", "stall reason", finish_reason, 2);
      check("R2", "stall no advance", advance_queue, 0);
      check("R2", "stall bytes kept", desc_bytes_left, 700);
      check("R2", "stall err kept", desc_err_cnt, 2);
   endtask

   task automatic t_collisions;
      load_desc(1, 0, 1, 700, 0);
      txn(0, 1, 1, 0, 512);
      check("R7", "stall beats error reason", finish_reason, 2);
      check("R7", "stall beats error count", desc_err_cnt, 1);
      load_desc(1, 0, 3, 700, 0);
      txn(1, 1, 0, 700, 512);
      check("R7", "error beats ok count", desc_err_cnt, 2);
      check("R7", "error beats ok bytes", desc_bytes_left, 700);
      check("R7", "error beats ok active", desc_active, 1);
      check("R7", "error beats ok advance", advance_queue, 0);
   endtask

   task automatic t_idle_ignored;
      load_desc(1, 0, 3, 700, 0);
      txn(0, 0, 1, 0, 512);
      txn(1, 0, 0, 300, 512);
      check("R8", "bytes after ok while halted", desc_bytes_left, 700);
      check("R8", "no advance while halted", advance_queue, 0);
      txn(0, 1, 0, 0, 512);
      check("R8", "err_cnt while halted", desc_err_cnt, 3);
      check("R8", "halt persists", desc_halted, 1);
      check("R8", "reason kept", finish_reason, 2);
      @(negedge clk);
      check("R8", "halt still persists", desc_halted, 1);
   endtask

   task automatic t_load_priority;
      @(negedge clk);
      load_en    = 1'b1;
      ld_active  = 1'b1;
      ld_halted  = 1'b0;
      ld_err_cnt = 2'd1;
      ld_bytes   = 15'd40;
      ld_token   = 2'b01;
      txn_stall  = 1'b1;
      txn_ok     = 1'b1;
      txn_moved  = 11'd40;
      @(posedge clk);
      @(negedge clk);
      load_en   = 1'b0;
      txn_stall = 1'b0;
      txn_ok    = 1'b0;
      check("R10", "load beats stall active", desc_active, 1);
      check("R10", "load clears halt", desc_halted, 0);
      check("R10", "load clears reason", finish_reason, 0);
      check("R10", "load bytes", desc_bytes_left, 40);
      check("R10", "load token", desc_token, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total_checks++;
         bad_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_out_full();
      t_zero_length();
      t_short_in();
      t_short_out();
      t_short_and_empty();
      t_saturate();
      t_error_countdown();
      t_error_zero();
      t_stall();
      t_collisions();
      t_idle_ignored();
      t_load_priority();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
   end

endmodule